// File: doc/BRIEF.md
# Two-wire serial slave with register-file access

This block is a two-wire serial bus slave that an external master uses to read and write a sixteen-entry byte register file. It runs on a fast system clock and oversamples the clock and data lines. Each line first passes a two-flop synchroniser and then a persistence filter, so short spikes are rejected. From the filtered lines it detects START, STOP and repeated START conditions. It then compares the seven-bit device address and acknowledges only its own address, by pulling the data line low through an open-drain style output.

In a write transfer, the byte that follows the address byte loads a four-bit word pointer from its low nibble. Each later byte is written to the register the pointer selects, and the pointer then advances. In a read transfer, bytes stream out from the current pointer, and the pointer advances after each one. The pointer survives the end of a transfer, so a read that sets no pointer continues where the last access stopped. The register file itself sits outside the block. The block drives the address, write data, a write strobe and a read strobe, and it expects the read data to come back combinationally.

Top module: `i2c_regif`

## Requirements
- R1: A byte after START whose upper seven bits equal DEV_ADDR (default 7'h51, so 8'hA2 for write and 8'hA3 for read) is acknowledged by pulling the data line low during the ninth clock pulse.
- R2: A byte after START with any other address is not acknowledged. After it, the bus is ignored until the next START: no register is written, the pointer does not change, and the data line is never pulled.
- R3: In a write transfer, the first byte after the address loads the pointer from bits 3:0 only. Bits 7:4 have no effect, and the byte is acknowledged.
- R4: Each later write byte is acknowledged and written with a one-cycle write strobe to the register the pointer selects. The pointer then advances by one.
- R5: In a read transfer, bytes are sent MSB first, starting from the register the pointer selects. The pointer advances by one after each byte, and the next byte is sent while the master acknowledges.
- R6: A read with no preceding pointer write starts at the pointer value left by the previous transfer.
- R7: The pointer wraps from 4'hF to 4'h0 in both write and read streams.
- R8: When the master does not acknowledge a read byte, the slave keeps the data line released, so the master can issue STOP.
- R9: A repeated START returns the slave to address matching, in both directions.
- R10: A pulse on either line that is shorter than FILT_CYCLES system clocks (default 6, which is 60 ns at 100 MHz) is ignored.
- R11: After STOP the data line is released. Bytes clocked without a new START are neither acknowledged nor written.
- R12: After reset, the data line is released, both strobes are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull the data line low |
| reg_addr_o | output | 4 | Register-file address, equal to the word pointer |
| reg_wdata_o | output | 8 | Register-file write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register-file read data for reg_addr_o, combinational |
| reg_re_o | output | 1 | One-cycle read strobe; data is taken on the next clock edge |

## Verification
A bus edge reaches the filtered lines 2 + FILT_CYCLES system clocks after it appears at the pins. The acknowledge pull and the first data bit of a read byte follow one or two clocks after the filtered falling edge of SCL. The bench therefore holds every SCL phase for 20 clocks and samples the data line in the middle of the high phase, long after any change from the slave has settled. Writes land in the bench's register model one clock after the write strobe, and the pointer advances on that same edge. The bench compares register contents only after STOP, and the contents of any read byte only after all eight bits have been shifted in.

// File: rtl/i2c_regif.sv
module i2c_regif #(
  parameter logic [6:0] DEV_ADDR    = 7'h51,
  parameter int         FILT_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [3:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  input  logic [7:0] reg_rdata_i,
  output logic       reg_re_o
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam logic [1:0] K_ADDR = 2'd0, K_PTR = 2'd1, K_DATA = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;

  logic [1:0] raw, sy1, sy2, filt, filt_q;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sy1[g]    <= 1'b1;
        sy2[g]    <= 1'b1;
        filt[g]   <= 1'b1;
        filt_q[g] <= 1'b1;
        cnt       <= '0;
      end else begin
        sy1[g]    <= raw[g];
        sy2[g]    <= sy1[g];
        filt_q[g] <= filt[g];
        if (sy2[g] == filt[g]) cnt <= '0;
        else if (cnt == FW'(FILT_CYCLES - 1)) begin
          filt[g] <= sy2[g];
          cnt     <= '0;
        end else cnt <= FW'(cnt + 1'b1);
      end
    end
  end

  logic scl_f, sda_f, start_det, stop_det, scl_rise, scl_fall;
  assign scl_f     = filt[0];
  assign sda_f     = filt[1];
  assign start_det = scl_f & filt_q[0] & filt_q[1] & ~sda_f;
  assign stop_det  = scl_f & filt_q[0] & ~filt_q[1] & sda_f;
  assign scl_rise  = scl_f & ~filt_q[0];
  assign scl_fall  = ~scl_f & filt_q[0];

  st_t        st;
  logic [3:0] bitcnt, ptr;
  logic [7:0] shreg;
  logic [1:0] kind;
  logic       rd, more;

  assign reg_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bitcnt      <= '0;
      ptr         <= '0;
      shreg       <= '0;
      kind        <= K_ADDR;
      rd          <= 1'b0;
      more        <= 1'b0;
      sda_pull_o  <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (reg_we_o || reg_re_o) ptr <= 4'(ptr + 1'b1);
      if (reg_re_o) begin
        shreg      <= reg_rdata_i;
        sda_pull_o <= ~reg_rdata_i[7];
      end
      if (start_det) begin
        st         <= S_RX;
        bitcnt     <= '0;
        kind       <= K_ADDR;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= 4'(bitcnt + 1'b1);
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd         <= shreg[0];
                    kind       <= K_PTR;
                    sda_pull_o <= 1'b1;
                    st         <= S_ACK;
                  end else st <= S_IDLE;
                end
                K_PTR: begin
                  ptr        <= shreg[3:0];
                  kind       <= K_DATA;
                  sda_pull_o <= 1'b1;
                  st         <= S_ACK;
                end
                default: begin
                  reg_we_o    <= 1'b1;
                  reg_wdata_o <= shreg;
                  sda_pull_o  <= 1'b1;
                  st          <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              if (rd) begin
                reg_re_o <= 1'b1;
                st       <= S_TX;
              end else st <= S_RX;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_pull_o <= 1'b0;
                bitcnt     <= '0;
                st         <= S_MACK;
              end else begin
                bitcnt     <= 4'(bitcnt + 1'b1);
                shreg      <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) more <= ~sda_f;
            else if (scl_fall) begin
              if (more) begin
                reg_re_o <= 1'b1;
                st       <= S_TX;
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regif_chk.sv
module i2c_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       stop_det,
  input logic       sda_pull_o,
  input logic       reg_we_o,
  input logic       reg_re_o,
  input logic [3:0] reg_addr_o
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we_o || reg_re_o) |-> reg_addr_o == 4'($past(reg_addr_o) + 4'd1)); // R7

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o)); // R5

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull_o)); // R5

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R11
endmodule

bind i2c_regif i2c_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_det(stop_det),
  .sda_pull_o(sda_pull_o), .reg_we_o(reg_we_o), .reg_re_o(reg_re_o),
  .reg_addr_o(reg_addr_o)
);

// File: tb/i2c_regif_tb.sv
module i2c_regif_tb;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, reg_we, reg_re;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [16];
  logic [7:0] model [16];
  int vectors = 0, miscompares = 0;
  bit done = 0, watch = 0, pulled = 0;
  wire sda_line = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regif u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_we_o(reg_we), .reg_rdata_i(reg_rdata), .reg_re_o(reg_re)
  );

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (watch && sda_pull) pulled <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask

  task automatic bit_cycle(input bit b, input bit gl, output bit r);
    sda_m = b;
    wq(Q / 2);
    if (gl) begin scl_m = 1; wq(5); scl_m = 0; end
    wq(Q / 2);
    scl_m = 1; wq(Q / 2);
    if (gl) begin sda_m = ~b; wq(5); sda_m = b; end
    wq(Q / 2);
    r = sda_line;
    wq(Q);
    scl_m = 0; wq(Q);
  endtask

  task automatic send(input logic [7:0] d, input int gl_pos, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], (7 - i) == gl_pos, r);
    bit_cycle(1'b1, 1'b0, r);
    ack = ~r;
  endtask

  task automatic recv(input bit mack, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, 1'b0, r); d[i] = r; end
    bit_cycle(~mack, 1'b0, r);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; model[i] = 8'h00; end
    wq(10);
    chk(sda_pull == 0 && reg_we == 0 && reg_re == 0 && reg_addr == 0, "R12 reset",
        {sda_pull, reg_we, reg_re, reg_addr}, 0);
    rst_n = 1; wq(10);

    // R3 R4: pointer byte with upper nibble set, then 16 data bytes
    bus_start();
    send(8'hA2, -1, ack); chk(ack, "R1 write addr ack", ack, 1);
    send(8'hA0, -1, ack); chk(ack, "R3 pointer ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      send(pat(i), -1, ack); model[i] = pat(i);
      chk(ack, "R4 data ack", ack, 1);
    end
    bus_stop();
    for (int i = 0; i < 16; i++) chk(mem[i] == model[i], "R4 R3 write", mem[i], model[i]);

    // R7: write stream wraps
    bus_start();
    send(8'hA2, -1, ack); send(8'h3E, -1, ack);
    send(8'hC1, -1, ack); model[14] = 8'hC1;
    send(8'hC2, -1, ack); model[15] = 8'hC2;
    send(8'hC3, -1, ack); model[0]  = 8'hC3;
    bus_stop();
    chk(mem[14] == 8'hC1, "R7 wr E", mem[14], 8'hC1);
    chk(mem[15] == 8'hC2, "R7 wr F", mem[15], 8'hC2);
    chk(mem[0]  == 8'hC3, "R7 wr 0", mem[0], 8'hC3);

    // R6 R5 R8: read without pointer write, pointer is 1
    bus_start();
    send(8'hA3, -1, ack); chk(ack, "R1 read addr ack", ack, 1);
    recv(1'b1, d); chk(d == model[1], "R6 first read", d, model[1]);
    recv(1'b0, d); chk(d == model[2], "R5 second read", d, model[2]);
    wq(4);
    chk(sda_pull == 0, "R8 release after nack", sda_pull, 0);
    bus_stop();
    chk(sda_line == 1, "R8 stop possible", sda_line, 1);

    // R9 R5 R7: pointer write, repeated START, read 12 bytes wrapping
    bus_start();
    send(8'hA2, -1, ack); send(8'h05, -1, ack);
    bus_start();
    send(8'hA3, -1, ack); chk(ack, "R9 rstart read ack", ack, 1);
    for (int k = 0; k < 12; k++) begin
      recv(k < 11, d);
      chk(d == model[(5 + k) % 16], "R5 R7 stream read", d, model[(5 + k) % 16]);
    end
    bus_stop();

    // R2: wrong address, pointer left at 1
    watch = 1; pulled = 0;
    bus_start();
    send(8'hA4, -1, ack); chk(!ack, "R2 no ack", ack, 0);
    send(8'h07, -1, ack); send(8'h55, -1, ack);
    bus_stop();
    wq(2); watch = 0;
    chk(!pulled, "R2 line never pulled", pulled, 0);
    for (int i = 0; i < 16; i++) chk(mem[i] == model[i], "R2 no write", mem[i], model[i]);
    bus_start();
    send(8'hA3, -1, ack); recv(1'b0, d);
    chk(d == model[1], "R2 pointer kept", d, model[1]);
    bus_stop();

    // R10: glitches on both lines inside a data bit
    bus_start();
    send(8'hA2, -1, ack); send(8'h08, -1, ack);
    send(8'h5A, 3, ack); model[8] = 8'h5A;
    chk(ack, "R10 glitch byte ack", ack, 1);
    bus_stop();
    chk(mem[8] == 8'h5A, "R10 glitch data", mem[8], 8'h5A);
    chk(mem[9] == model[9], "R10 no extra write", mem[9], model[9]);

    // R11: bytes after STOP without START
    send(8'hA2, -1, ack); chk(!ack, "R11 no ack w/o start", ack, 0);
    send(8'h03, -1, ack); send(8'h77, -1, ack);
    bus_stop();
    chk(mem[3] == model[3], "R11 no write", mem[3], model[3]);

    // R9: repeated START between two writes
    bus_start();
    send(8'hA2, -1, ack); send(8'h02, -1, ack); send(8'h11, -1, ack); model[2] = 8'h11;
    bus_start();
    send(8'hA2, -1, ack); chk(ack, "R9 rstart write ack", ack, 1);
    send(8'h09, -1, ack); send(8'h22, -1, ack); model[9] = 8'h22;
    bus_stop();
    chk(mem[2] == 8'h11, "R9 first write", mem[2], 8'h11);
    chk(mem[9] == 8'h22, "R9 second write", mem[9], 8'h22);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule